// File: doc/BRIEF.md
# Radix-4 four-valued coefficient digit recoder

This block turns a two's-complement coefficient of `WIDTH` = 2k bits into k radix-4 digits, ready to be stored in a coefficient memory and consumed later by a partial-product stage. Every digit except the top one uses only four values {−2, −1, 0, +1}. Each of those digits takes just two bits of storage. The top digit may take any of the five values {−2, …, +2}. With that one wider digit, the whole signed range of the input can still be represented.

The digits come from a ripple of simple adder cells. For each digit position, an ordinary half adder combines the even input bit with the incoming carry. A second half adder, whose sum output counts negatively, then folds in the odd bit. The carry out of the second cell feeds the next digit. The top position takes the last carry and emits a sign/one/two field. The combinational result is captured in an output register, so the coded word appears one clock after the coefficient is presented.

Top module: `nr4sd_encoder`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `code_o` becomes all zeros (every digit zero), whatever the value of `coef_i`.
- R2: With `rst_n` high, the coefficient sampled at a rising edge is reflected in `code_o` right after that same edge, and `code_o` then holds until the next edge.
- R3: Low digit j (0 ≤ j < k−1) occupies `code_o[2j+1:2j]` as the pair {hi, lo}, decoded as 00→0, 01→+1, 10→−2, 11→−1 (value = lo − 2·hi).
- R4: The carry entering digit 0 is zero, so coefficient 1 yields digit 0 = 01, coefficient 2 yields digit 0 = 10 and digit 1 = 01, and coefficient 0 yields an all-zero word.
- R5: The top digit occupies `code_o[2k:2k-2]` as {sign, two, one}, with value (sign ? −1 : +1)·(one + 2·two). `one` and `two` are never both set, and `sign` is never set with a zero magnitude.
- R6: For every input value, the sum over all digits of digit·4^j equals the signed value of the coefficient.
- R7: The most negative coefficient (only the MSB set) gives top digit −2 (field 110) with all low digits zero. The most positive coefficient gives top digit +2 (field 010), low digit 0 = −1 (11), and all other low digits zero.
- R8: A carry that ripples through the whole chain stays exact: coefficient −1 (all ones) gives low digit 0 = −1 (11) and a top digit of exactly zero (field 000), with every other low digit zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| coef_i | input | WIDTH | Two's-complement coefficient to recode |
| code_o | output | WIDTH+1 | Registered digit word: low pairs, then the {sign, two, one} top field |

## Verification
Every result of this block is due exactly one rising edge after its coefficient is applied. There is one output register and the adder chain is purely combinational, so nothing arrives later than that single edge. The bench drives `coef_i` on a falling edge and reads `code_o` on the following falling edge, half a period after the capturing edge. At that point the value is settled and no earlier or later word can be mistaken for it. For reset, the bench holds `rst_n` low across an edge with a nonzero coefficient present and reads the word on the falling edge after it. It then confirms that the next word after release reflects the coefficient applied at that release edge.

// File: rtl/nr4sd_pkg.sv
// Package: shared types for the four-valued radix-4 recoder.
// Assumes: nothing beyond IEEE 1800-2017 packed structs.
package nr4sd_pkg;

    // Field for the five-valued top digit, stored MSB first as {sign, two, one}
    typedef struct packed {
        logic sign;
        logic two;
        logic one;
    } top_field_t;

    // Pair for one four-valued low digit, stored as {hi, lo}; value = lo - 2*hi
    typedef struct packed {
        logic hi;
        logic lo;
    } low_pair_t;

endpackage

// File: rtl/nr4sd_digit_cell.sv
// Module: nr4sd_digit_cell
// Recodes one radix-4 position into a four-valued digit {-2,-1,0,+1}.
// A plain half adder combines the even bit with the incoming carry. A second
// half adder, whose sum is negatively weighted, folds in the odd bit and
// produces the carry for the next position.
// Assumes: purely combinational; the caller supplies the carry chain.
module nr4sd_digit_cell
    import nr4sd_pkg::*;
(
    input  logic      bit_even_i,
    input  logic      bit_odd_i,
    input  logic      carry_i,
    output low_pair_t pair_o,
    output logic      carry_o
);

    logic mid_carry;

    // First half adder: positive sum, carry passed to the second stage
    always_comb begin
        pair_o.lo = bit_even_i ^ carry_i;
        mid_carry = bit_even_i & carry_i;
    end

    // Second half adder: 2*carry_o - hi == bit_odd + mid_carry
    always_comb begin
        pair_o.hi = bit_odd_i ^ mid_carry;
        carry_o   = bit_odd_i | mid_carry;
    end

    // Arithmetic balance of the position: digit + 4*carry_out == local input weight
    always_comb begin
        assert_digit_balance_R3: assert (
            (32'(pair_o.lo) - 2 * 32'(pair_o.hi) + 4 * 32'(carry_o)) ==
            (32'(bit_even_i) + 2 * 32'(bit_odd_i) + 32'(carry_i)))
            else $error("digit cell out of balance");
    end

endmodule

// File: rtl/nr4sd_top_digit.sv
// Module: nr4sd_top_digit
// Forms the most significant, five-valued digit from the top two bits and the
// carry that reaches them: value = -2*bit_odd + bit_even + carry_in.
// Emits it as {sign, two, one}; a zero digit is always written as 000.
// Assumes: purely combinational; the carry comes from the last low cell.
module nr4sd_top_digit
    import nr4sd_pkg::*;
(
    input  logic       bit_even_i,
    input  logic       bit_odd_i,
    input  logic       carry_i,
    output top_field_t field_o
);

    logic both_set;
    logic none_set;

    // Partial sum bit_even + carry_in is 0, 1 or 2
    always_comb begin
        both_set = bit_even_i & carry_i;
        none_set = ~bit_even_i & ~carry_i;
    end

    // Magnitude and sign of -2*bit_odd + partial sum
    always_comb begin
        field_o.one  = bit_even_i ^ carry_i;
        field_o.two  = bit_odd_i ? none_set : both_set;
        field_o.sign = bit_odd_i & ~both_set;
    end

    // Encoded field must decode back to the arithmetic value of the position
    always_comb begin
        assert_top_value_R5: assert (
            (field_o.sign ? -(32'(field_o.one) + 2 * 32'(field_o.two))
                          :  (32'(field_o.one) + 2 * 32'(field_o.two))) ==
            (32'(bit_even_i) + 32'(carry_i) - 2 * 32'(bit_odd_i)))
            else $error("top digit value mismatch");
    end

endmodule

// File: rtl/nr4sd_encoder.sv
// Module: nr4sd_encoder (top)
// Recodes a WIDTH-bit two's-complement coefficient into WIDTH/2 radix-4
// digits: four-valued low digits (2 bits each) and a five-valued top digit
// (3 bits). The ripple chain is combinational; the word is registered.
// Assumes: WIDTH is even and at least 4; synchronous active-low reset.
module nr4sd_encoder
    import nr4sd_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] coef_i,
    output logic [WIDTH:0]   code_o
);

    localparam int DIGITS = WIDTH / 2;
    localparam int LOW_N  = DIGITS - 1;
    localparam int CODE_W = 2 * LOW_N + 3;

    logic [LOW_N:0]    carry;
    logic [CODE_W-1:0] code_next;
    top_field_t        top_field;
    logic              past_ok;

    // No carry enters the least significant position
    assign carry[0] = 1'b0;

    // One cell per low digit, chained through the carry vector
    for (genvar j = 0; j < LOW_N; j++) begin : g_low
        low_pair_t pair;
        nr4sd_digit_cell i_cell (
            .bit_even_i (coef_i[2*j]),
            .bit_odd_i  (coef_i[2*j+1]),
            .carry_i    (carry[j]),
            .pair_o     (pair),
            .carry_o    (carry[j+1])
        );
        assign code_next[2*j+1 -: 2] = pair;
    end

    nr4sd_top_digit i_top (
        .bit_even_i (coef_i[WIDTH-2]),
        .bit_odd_i  (coef_i[WIDTH-1]),
        .carry_i    (carry[LOW_N]),
        .field_o    (top_field)
    );

    assign code_next[CODE_W-1 -: 3] = top_field;

    // Output register: cleared in reset, otherwise loads the recoded word
    always_ff @(posedge clk) begin
        if (!rst_n) code_o <= '0;
        else        code_o <= code_next;
    end

    // Marks that the previous edge loaded a real coefficient
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // Weighted digit sum of a coded word
    function automatic longint word_value(input logic [CODE_W-1:0] w);
        longint acc = 0;
        longint wt  = 1;
        for (int i = 0; i < LOW_N; i++) begin
            acc += wt * (longint'(w[2*i]) - 2 * longint'(w[2*i+1]));
            wt  *= 4;
        end
        if (w[CODE_W-1])
            acc -= wt * (longint'(w[CODE_W-3]) + 2 * longint'(w[CODE_W-2]));
        else
            acc += wt * (longint'(w[CODE_W-3]) + 2 * longint'(w[CODE_W-2]));
        return acc;
    endfunction

    assert_word_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (word_value(code_o) == longint'($signed($past(coef_i)))))
        else $error("coded word does not match previous coefficient");

    assert_top_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(code_o[CODE_W-2] && code_o[CODE_W-3]))
        else $error("top field has one and two both set");

    assert_top_no_neg_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        code_o[CODE_W-1] |-> (code_o[CODE_W-2] || code_o[CODE_W-3]))
        else $error("top field negative zero");

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (code_o == '0))
        else $error("word not cleared by reset");

endmodule

// File: tb/test_nr4sd_encoder.sv
module test_nr4sd_encoder;

    localparam int CLK_PERIOD = 10;
    localparam int WIDTH      = 8;
    localparam int DIGITS     = WIDTH / 2;
    localparam int CODE_W     = WIDTH + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [WIDTH-1:0]  coef_i = '0;
    logic [CODE_W-1:0] code_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    nr4sd_encoder #(.WIDTH(WIDTH)) i_nr4sd_encoder (
        .clk    (clk),
        .rst_n  (rst_n),
        .coef_i (coef_i),
        .code_o (code_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Compare one word against an expected value
    task automatic check_word(input string req, input logic [CODE_W-1:0] exp);
        total++;
        if (code_o !== exp) begin
            bad++;
            $display("FAIL %s: code_o actual=%h expected=%h", req, code_o, exp);
        end
    endtask

    // Drive a coefficient on a falling edge, return on the next falling edge
    task automatic apply(input logic [WIDTH-1:0] v);
        @(negedge clk);
        coef_i = v;
        @(negedge clk);
    endtask

    // Independent decode of the word: R3 pairs and R5 top field
    function automatic int decode(input logic [CODE_W-1:0] w);
        int acc = 0;
        int wt  = 1;
        for (int j = 0; j < DIGITS - 1; j++) begin
            case (w[2*j+1 -: 2])
                2'b00: acc += 0;
                2'b01: acc += wt;
                2'b10: acc -= 2 * wt;
                default: acc -= wt;
            endcase
            wt *= 4;
        end
        case (w[CODE_W-1 -: 3])
            3'b001: acc += wt;
            3'b010: acc += 2 * wt;
            3'b101: acc -= wt;
            3'b110: acc -= 2 * wt;
            default: acc += 0;
        endcase
        return acc;
    endfunction

    task automatic t_reset;
        rst_n  = 1'b0;
        @(negedge clk);
        coef_i = 8'h5A;
        @(negedge clk);
        check_word("R1", '0);
        @(negedge clk);
        rst_n = 1'b1;
        // Release edge loads 0x5A
        @(negedge clk);
        total++;
        if (decode(code_o) != int'($signed(8'h5A))) begin
            bad++;
            $display("FAIL R2: value actual=%0d expected=%0d", decode(code_o), int'($signed(8'h5A)));
        end
    endtask

    task automatic t_latency;
        @(negedge clk);
        coef_i = 8'd1;
        @(posedge clk);
        #1;
        coef_i = 8'd2;
        // Word captured from 1 must hold until the next edge
        check_word("R2", 9'h001);
        @(negedge clk);
        check_word("R2", 9'h001);
        @(negedge clk);
        check_word("R2", 9'h006);
    endtask

    task automatic t_low_digits;
        apply(8'd0);  check_word("R4", 9'h000);
        apply(8'd1);  check_word("R4", 9'h001);
        apply(8'd2);  check_word("R4", 9'h006);
        apply(8'd3);  check_word("R3", 9'h007);
        apply(8'd12); check_word("R3", 9'h01C);
    endtask

    task automatic t_extremes;
        apply(8'h80); check_word("R7", 9'h180);
        apply(8'h7F); check_word("R7", 9'h083);
        apply(8'hFF); check_word("R8", 9'h003);
    endtask

    task automatic t_all_values;
        for (int v = 0; v < (1 << WIDTH); v++) begin
            apply(WIDTH'(v));
            total++;
            if (decode(code_o) != int'($signed(WIDTH'(v)))) begin
                bad++;
                $display("FAIL R6: coef=%0d actual=%0d expected=%0d",
                         v, decode(code_o), int'($signed(WIDTH'(v))));
            end
            total++;
            if ((code_o[CODE_W-2] && code_o[CODE_W-3]) ||
                (code_o[CODE_W-1] && !code_o[CODE_W-2] && !code_o[CODE_W-3])) begin
                bad++;
                $display("FAIL R5: coef=%0d top actual=%b expected=legal field",
                         v, code_o[CODE_W-1 -: 3]);
            end
        end
    endtask

    initial begin
        t_reset();
        t_latency();
        t_low_digits();
        t_extremes();
        t_all_values();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule